// File: doc/BRIEF.md
# S/PDIF Channel-Status Capture Buffer

This block collects the 192-bit channel-status block of a digital audio stream, one bit per frame, from subframes that an upstream decoder has already taken apart. For every subframe the decoder presents a strobe, a flag that says whether the subframe belongs to channel A or channel B, the extracted status bit, and a marker on the subframe that opens a new block. One control input chooses which of the two channels is captured.

Bits of the chosen channel are gathered in a shadow buffer. Gathering starts at a block marker and continues until all 192 bits are present. The complete block is then copied in a single cycle into a readable buffer. A 3-bit word index picks one of six 32-bit words of that buffer for a combinational read port. A marker that arrives before a block is complete throws the partial block away and starts again. Once a block is complete, further subframes are ignored until the next marker.

Top module: `chsts_capture`

## Requirements
- R1: With `rst_n` low at a clock edge, the shadow buffer, the bit counter and the readable buffer are all cleared, so every word index reads zero afterwards.
- R2: Collection starts only at a subframe of the selected channel that has `block_start` high. Selected-channel subframes that arrive before any marker change no readable word.
- R3: Block bit k (k = 0 is the marker subframe) is stored at bit k mod 32 of word k/32. Each byte therefore sits with its first-received bit in bit 0, byte j of a word occupies bits 8j+7:8j, and word i holds status bytes 4i to 4i+3.
- R4: With `chan_sel_b` = 0 only subframes with `sub_is_b` = 0 (channel A) are used, and with `chan_sel_b` = 1 only subframes with `sub_is_b` = 1 (channel B). Subframes of the other channel have no effect, including their markers.
- R5: The readable buffer changes only in the cycle after the 192nd bit of a block is accepted, and all six words change together. Until then reads return the previous complete block.
- R6: A selected-channel marker that arrives before 192 bits are collected discards the partial block and restarts collection with that subframe's bit as bit 0.
- R7: Word indices 6 and 7 read as all zeros.
- R8: After a block completes, selected-channel subframes without a marker are ignored until the next marker.
- R9: Cycles with `sub_valid` low have no effect, whatever `sub_is_b`, `status_bit` and `block_start` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sub_valid | input | 1 | One subframe is presented this cycle |
| sub_is_b | input | 1 | Subframe channel: 0 = A, 1 = B |
| status_bit | input | 1 | Channel-status bit carried by the subframe |
| block_start | input | 1 | Subframe is the first frame of a status block |
| chan_sel_b | input | 1 | Channel to capture: 0 = A, 1 = B |
| word_idx | input | 3 | Readable word to present (0 to 5) |
| rd_word | output | 32 | Selected 32-bit word of the last complete block |

## Verification
The embedded properties check on every cycle that the readable buffer holds still except in the cycle after a completion, and that a completion loads exactly the assembled block. They also check that an accepted marker leaves the counter at one, that a completion disarms the collector, that the counter stays inside the block, that other-channel subframes leave the read port unchanged, and that indices 6 and 7 read zero. Only the bench scenarios can show the bit-to-byte-to-word placement against independently built byte patterns. The same holds for discarding a partial block and for ignoring bits before the first marker or after a finished block. Those effects appear at the read port only after a whole block, and often only as the absence of a change.

// File: rtl/chsts_pkg.sv
// Package: shared sizing for the channel-status capture buffer.
// Assumes: a block is a whole number of read words.
package chsts_pkg;
    localparam int unsigned CS_BLOCK_BITS = 192;
    localparam int unsigned CS_WORD_W     = 32;
endpackage

// File: rtl/chsts_collector.sv
// Module: chsts_collector
// Gathers one status block, bit by bit, into a shadow register and flags
// the cycle in which the final bit arrives. The assembled block, including
// that final bit, is presented combinationally for the store to copy.
// Assumes: `take` is already qualified by strobe and channel selection.
module chsts_collector #(
    parameter int unsigned BLOCK_BITS = 192,
    parameter int unsigned CNT_W      = $clog2(BLOCK_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take,
    input  logic                  mark,
    input  logic                  bit_in,
    output logic                  commit,
    output logic [BLOCK_BITS-1:0] blk_out
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(BLOCK_BITS - 1);
    localparam logic [CNT_W-1:0] ONE_POS  = CNT_W'(1);

    logic [BLOCK_BITS-1:0] shadow;
    logic [CNT_W-1:0]      cnt;
    logic                  armed;

    // Final bit of an armed block that is not itself a restart.
    assign commit = take && !mark && armed && (cnt == LAST_POS);

    // Present the shadow with the incoming final bit merged in.
    always_comb begin
        blk_out                 = shadow;
        blk_out[BLOCK_BITS-1]   = bit_in;
    end

    // Shadow, position counter and armed flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            cnt    <= '0;
            armed  <= 1'b0;
        end else if (take) begin
            if (mark) begin
                shadow[0] <= bit_in;
                cnt       <= ONE_POS;
                armed     <= 1'b1;
            end else if (armed) begin
                shadow[cnt] <= bit_in;
                if (cnt == LAST_POS) begin
                    cnt   <= '0;
                    armed <= 1'b0;
                end else begin
                    cnt <= cnt + ONE_POS;
                end
            end
        end
    end

    // R6
    mark_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mark) |=> (armed && cnt == ONE_POS));

    // R8
    done_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (!armed && cnt == '0));

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_POS);
endmodule

// File: rtl/chsts_store.sv
// Module: chsts_store
// Holds the last complete status block. Loads all bits at once on commit.
// Assumes: commit is a single-cycle pulse from the collector.
module chsts_store #(
    parameter int unsigned BLOCK_BITS = 192
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  logic [BLOCK_BITS-1:0] blk_in,
    output logic [BLOCK_BITS-1:0] held
);
    // Atomic copy of the finished block.
    always_ff @(posedge clk) begin
        if (!rst_n)      held <= '0;
        else if (commit) held <= blk_in;
    end

    // R5
    hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(held));

    // R5
    load_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (held == $past(blk_in)));
endmodule

// File: rtl/chsts_word_mux.sv
// Module: chsts_word_mux
// Slices the held block into words and returns the indexed one. Indices
// beyond the last word return zero.
// Assumes: 2**IDX_W >= NUM_WORDS.
module chsts_word_mux #(
    parameter int unsigned BLOCK_BITS = 192,
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned NUM_WORDS  = BLOCK_BITS / WORD_W,
    parameter int unsigned IDX_W      = 3
) (
    input  logic [BLOCK_BITS-1:0] held,
    input  logic [IDX_W-1:0]      idx,
    output logic [WORD_W-1:0]     word
);
    logic [WORD_W-1:0] slices [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slice
        assign slices[g] = held[g*WORD_W +: WORD_W];
    end

    // Word select with zero default for unused indices.
    always_comb begin
        word = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (idx == IDX_W'(i)) word = slices[i];
        end
    end
endmodule

// File: rtl/chsts_capture.sv
// Module: chsts_capture (top)
// Captures the channel-status block of one selected channel from
// pre-decoded subframes and exposes it as indexed 32-bit words.
// Assumes: upstream supplies one subframe per sub_valid cycle, with the
// block marker on the first frame of each block.
module chsts_capture #(
    parameter int unsigned BLOCK_BITS = chsts_pkg::CS_BLOCK_BITS,
    parameter int unsigned WORD_W     = chsts_pkg::CS_WORD_W,
    parameter int unsigned IDX_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sub_valid,
    input  logic              sub_is_b,
    input  logic              status_bit,
    input  logic              block_start,
    input  logic              chan_sel_b,
    input  logic [IDX_W-1:0]  word_idx,
    output logic [WORD_W-1:0] rd_word
);
    localparam int unsigned NUM_WORDS = BLOCK_BITS / WORD_W;

    logic                  take;
    logic                  commit;
    logic [BLOCK_BITS-1:0] blk_asm;
    logic [BLOCK_BITS-1:0] held;

    // Accept only strobed subframes of the selected channel.
    assign take = sub_valid && (sub_is_b == chan_sel_b);

    chsts_collector #(.BLOCK_BITS(BLOCK_BITS)) u_collect (
        .clk(clk), .rst_n(rst_n), .take(take), .mark(block_start),
        .bit_in(status_bit), .commit(commit), .blk_out(blk_asm)
    );

    chsts_store #(.BLOCK_BITS(BLOCK_BITS)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit), .blk_in(blk_asm),
        .held(held)
    );

    chsts_word_mux #(
        .BLOCK_BITS(BLOCK_BITS), .WORD_W(WORD_W),
        .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
    ) u_mux (
        .held(held), .idx(word_idx), .word(rd_word)
    );

    // R7
    idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_idx >= IDX_W'(NUM_WORDS)) |-> (rd_word == '0));

    // R4
    other_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && sub_is_b != chan_sel_b)
            |=> (!$stable(word_idx) || $stable(rd_word)));
endmodule

// File: tb/chsts_capture_bench.sv
module chsts_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sub_valid = 1'b0;
    logic        sub_is_b = 1'b0;
    logic        status_bit = 1'b0;
    logic        block_start = 1'b0;
    logic        chan_sel_b = 1'b0;
    logic [2:0]  word_idx = 3'd0;
    logic [31:0] rd_word;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    chsts_capture u_chsts_capture (
        .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_is_b(sub_is_b),
        .status_bit(status_bit), .block_start(block_start),
        .chan_sel_b(chan_sel_b), .word_idx(word_idx), .rd_word(rd_word)
    );

    // Status byte b of the pattern with the given seed.
    function automatic logic [7:0] cs_byte(int seed, int b);
        return 8'((seed * 29 + b * 37 + 5) & 255);
    endfunction

    function automatic logic bit_of(int seed, int k);
        logic [7:0] v;
        v = cs_byte(seed, k / 8);
        return v[k % 8];
    endfunction

    // Word i: byte j at bits 8j+7:8j, bytes 4i..4i+3.
    function automatic logic [31:0] word_of(int seed, int i);
        logic [31:0] w;
        for (int j = 0; j < 4; j++) w[8*j +: 8] = cs_byte(seed, 4*i + j);
        return w;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sub(logic v, logic b, logic d, logic st);
        @(negedge clk);
        sub_valid = v; sub_is_b = b; status_bit = d; block_start = st;
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        sub_valid = 1'b0; block_start = 1'b0; status_bit = 1'b0;
    endtask

    // Send bits first..last of pattern `seed` on channel ch. Optional noise:
    // other-channel subframes with markers, and invalid cycles with markers.
    task automatic send(int seed, logic ch, int first, int last, bit marker,
                        bit other_noise, bit invalid_noise);
        for (int k = first; k <= last; k++) begin
            sub(1'b1, ch, bit_of(seed, k), marker && (k == first));
            if (other_noise)   sub(1'b1, ~ch, ~bit_of(seed, k), 1'b1);
            if (invalid_noise) sub(1'b0, ch, ~bit_of(seed, k), 1'b1);
        end
        idle();
    endtask

    task automatic expect_block(int seed, string req);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            word_idx = 3'(i);
            #1;
            chk(rd_word == word_of(seed, i), req, rd_word, word_of(seed, i));
        end
    endtask

    task automatic expect_zero(string req);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            word_idx = 3'(i);
            #1;
            chk(rd_word == 32'h0, req, rd_word, 32'h0);
        end
    endtask

    task automatic t_reset();
        expect_zero("R1 reset state");
    endtask

    task automatic t_before_marker();
        send(9, 1'b0, 0, 191, 1'b0, 1'b0, 1'b0);
        expect_zero("R2 bits before first marker ignored");
    endtask

    task automatic t_basic();
        send(1, 1'b0, 0, 191, 1'b1, 1'b1, 1'b0);
        expect_block(1, "R3 R4 channel A block placement");
    endtask

    task automatic t_atomic();
        send(2, 1'b0, 0, 99, 1'b1, 1'b0, 1'b0);
        expect_block(1, "R5 previous block held mid-collection");
        send(2, 1'b0, 100, 190, 1'b0, 1'b0, 1'b0);
        expect_block(1, "R5 held until final bit");
        send(2, 1'b0, 191, 191, 1'b0, 1'b0, 1'b0);
        expect_block(2, "R5 new block after final bit");
    endtask

    task automatic t_after_done();
        send(7, 1'b0, 0, 191, 1'b0, 1'b0, 1'b0);
        expect_block(2, "R8 unmarked bits after completed block ignored");
    endtask

    task automatic t_restart();
        send(5, 1'b0, 0, 59, 1'b1, 1'b0, 1'b0);
        send(3, 1'b0, 0, 191, 1'b1, 1'b0, 1'b0);
        expect_block(3, "R6 early marker restarts block");
    endtask

    task automatic t_chan_b();
        chan_sel_b = 1'b1;
        send(4, 1'b1, 0, 191, 1'b1, 1'b1, 1'b0);
        expect_block(4, "R4 channel B capture");
        chan_sel_b = 1'b0;
    endtask

    task automatic t_invalid();
        send(6, 1'b0, 0, 191, 1'b1, 1'b0, 1'b1);
        expect_block(6, "R9 invalid cycles ignored");
    endtask

    task automatic t_high_idx();
        for (int i = 6; i < 8; i++) begin
            @(negedge clk);
            word_idx = 3'(i);
            #1;
            chk(rd_word == 32'h0, "R7 index 6/7 reads zero", rd_word, 32'h0);
        end
    endtask

    task automatic t_reset_again();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        expect_zero("R1 reset clears held block");
        send(8, 1'b0, 100, 191, 1'b0, 1'b0, 1'b0);
        expect_zero("R1 reset clears collector");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_before_marker();
        t_basic();
        t_atomic();
        t_after_done();
        t_restart();
        t_chan_b();
        t_invalid();
        t_high_idx();
        t_reset_again();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule